// File: doc/BRIEF.md
# Translation Base Register Selector

This block sits in front of a translation table walker. It receives one lookup request at a time: a virtual address, the current exception level, a flag that says whether the translation regime is 64-bit or 32-bit, the raw translation control word, and the two region size fields. From these it decides which of the two translation table base registers the walk must start from. It also finds out whether the lookup must fault without a walk.

The decision has two steps. The first step picks the tag-ignore amount, which is the number of top address bits that are left out of the region checks. The second step tests whether the address lies in the low region (all zeros above the region) or in the high region (all ones above the region), using a fixed order of priority. The walk-disable bit of the selected base register is then applied. In a 64-bit regime at exception level 2 or 3 there is no high base register, so it can never be selected. The result is registered. It appears one cycle after the request is accepted and stays on the outputs until the next request is accepted.

Top module: `xlt_base_sel`

## Requirements
- R1: While reset is high, and on the first cycle after it, rsp_valid and rsp_fault are 0.
- R2: req_ready is always 1. rsp_valid is 1 in exactly the cycle after a cycle in which req_valid was 1, and 0 otherwise.
- R3: rsp_sel_hi, rsp_fault and rsp_tag_amt do not change until another request is accepted.
- R4: In a 64-bit regime at exception level 1, tag-ignore is enabled by control bit 38 when address bit 55 is 1, and by control bit 37 when address bit 55 is 0. When it is enabled, rsp_tag_amt is 8. Otherwise it is 0.
- R5: In a 64-bit regime at exception level 2 or 3, only control bit 20 enables tag-ignore. Address bit 55 has no effect.
- R6: In a 32-bit regime (req_aa64 = 0), the address size is 32 and rsp_tag_amt is 0 for every control word.
- R7: The region field for a size field T covers address bits from (S - T) up to (S - tag - 1), where S is the address size. The address is in the low region when the field is all zeros. It is in the high region when the field is all ones.
- R8: The selection order is as follows. (1) When req_t0sz is not 0 and the address is in the low region, register 0 is selected. (2) Otherwise, when the high register is valid, req_t1sz is not 0 and the address is in the high region, register 1 is selected. (3) Otherwise, when req_t0sz is 0, register 0 is selected. (4) Otherwise, when req_t1sz is 0 and the high register is valid, register 1 is selected. (5) Otherwise, rsp_fault is 1 and rsp_sel_hi is 0.
- R9: In a 64-bit regime at exception level 2 or 3, rsp_sel_hi is never 1.
- R10: When register 1 is selected and control bit 23 is 1, rsp_fault is 1.
- R11: When register 0 is selected and control bit 7 is 1, rsp_fault is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_va | input | 64 | Virtual address |
| req_el | input | 2 | Exception level, 0 to 3 |
| req_aa64 | input | 1 | 1 for a 64-bit regime, 0 for a 32-bit regime |
| req_ctl | input | 64 | Raw translation control word |
| req_t0sz | input | 6 | Size field of the low region |
| req_t1sz | input | 6 | Size field of the high region |
| rsp_valid | output | 1 | Result valid, one cycle after acceptance |
| rsp_sel_hi | output | 1 | 0 selects base register 0, 1 selects base register 1 |
| rsp_fault | output | 1 | Translation fault |
| rsp_tag_amt | output | 4 | Number of top address bits ignored (0 or 8) |

## Verification
The assertions check the following on every cycle:
- the response timing and the holding of the result between accepted requests;
- that the high register is never chosen in a 64-bit regime at exception level 2 or 3;
- that the tag amount is always 0 in a 32-bit regime;
- that a control word with both walk-disable bits set always faults.

Only the bench scenarios can show the rest:
- the order of priority between overlapping and empty regions;
- the exact placement of the region field and how it moves with the tag-ignore amount;
- which control bit enables tag-ignore, for each combination of exception level and address bit 55.

These cases are compared with a reference model over directed corner cases and seeded random requests.

// File: rtl/xlt_sel_pkg.sv
package xlt_sel_pkg;
    localparam int VA_W      = 64;
    localparam int CTL_W     = 64;
    localparam int SZ_W      = 6;
    localparam int EL_W      = 2;
    localparam int TAG_W     = 4;
    localparam int VA32_SIZE = 32;
    localparam int TAG_BITS  = 8;

    // control word bit positions
    localparam int CB_WALK_OFF_LO = 7;
    localparam int CB_TAG_UPPER   = 20;
    localparam int CB_WALK_OFF_HI = 23;
    localparam int CB_TAG_EL1_LO  = 37;
    localparam int CB_TAG_EL1_HI  = 38;
    localparam int VA_HALF_BIT    = 55;

    typedef enum logic [1:0] {
        PICK_LO   = 2'd0,
        PICK_HI   = 2'd1,
        PICK_NONE = 2'd2
    } pick_e;

    typedef struct packed {
        logic             sel_hi;
        logic             fault;
        logic [TAG_W-1:0] tag_amt;
    } xlt_result_t;

    function automatic logic is_upper_el(input logic aa64, input logic [EL_W-1:0] el);
        return aa64 && (el >= EL_W'(2));
    endfunction
endpackage

// File: rtl/xlt_tag_pick.sv
module xlt_tag_pick
    import xlt_sel_pkg::*;
#(
    parameter int TW = TAG_W
) (
    input  logic          aa64,
    input  logic          upper_el,
    input  logic          va_half,
    input  logic          tag_upper,
    input  logic          tag_el1_lo,
    input  logic          tag_el1_hi,
    output logic [TW-1:0] tag_amt
);
    logic enable;

    always_comb begin
        if (!aa64)          enable = 1'b0;
        else if (upper_el)  enable = tag_upper;
        else if (va_half)   enable = tag_el1_hi;
        else                enable = tag_el1_lo;
        tag_amt = enable ? TW'(TAG_BITS) : '0;
    end
endmodule

// File: rtl/xlt_region_match.sv
module xlt_region_match
    import xlt_sel_pkg::*;
#(
    parameter int  AW        = VA_W,
    parameter int  SW        = SZ_W,
    parameter int  TW        = TAG_W,
    parameter bit  MATCH_ONE = 1'b0
) (
    input  logic [AW-1:0] va,
    input  logic          aa64,
    input  logic [SW-1:0] tsz,
    input  logic [TW-1:0] tag_amt,
    output logic          hit
);
    logic [AW-1:0] span;
    logic [AW-1:0] probe;
    int            vsz;
    int            lo_edge;
    int            hi_edge;

    always_comb begin
        vsz     = aa64 ? AW : VA32_SIZE;
        lo_edge = vsz - int'(tsz);
        hi_edge = vsz - int'(tag_amt);
        for (int i = 0; i < AW; i++) begin
            span[i] = (i >= lo_edge) && (i < hi_edge);
        end
        probe = MATCH_ONE ? ~va : va;
        hit   = (tsz != '0) && ((probe & span) == '0);
    end
endmodule

// File: rtl/xlt_sel_arbiter.sv
module xlt_sel_arbiter
    import xlt_sel_pkg::*;
(
    input  logic hit_lo,
    input  logic hit_hi,
    input  logic t0_zero,
    input  logic t1_zero,
    input  logic hi_ok,
    input  logic walk_off_lo,
    input  logic walk_off_hi,
    output logic sel_hi,
    output logic fault
);
    pick_e pick;

    always_comb begin
        if (hit_lo)                    pick = PICK_LO;
        else if (hi_ok && hit_hi)      pick = PICK_HI;
        else if (t0_zero)              pick = PICK_LO;
        else if (t1_zero && hi_ok)     pick = PICK_HI;
        else                           pick = PICK_NONE;

        unique case (pick)
            PICK_LO: begin sel_hi = 1'b0; fault = walk_off_lo; end
            PICK_HI: begin sel_hi = 1'b1; fault = walk_off_hi; end
            default: begin sel_hi = 1'b0; fault = 1'b1;        end
        endcase
    end
endmodule

// File: rtl/xlt_base_sel.sv
module xlt_base_sel
    import xlt_sel_pkg::*;
#(
    parameter int AW  = VA_W,
    parameter int CW  = CTL_W,
    parameter int SW  = SZ_W,
    parameter int EW  = EL_W,
    parameter int TW  = TAG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_va,
    input  logic [EW-1:0] req_el,
    input  logic          req_aa64,
    input  logic [CW-1:0] req_ctl,
    input  logic [SW-1:0] req_t0sz,
    input  logic [SW-1:0] req_t1sz,
    output logic          rsp_valid,
    output logic          rsp_sel_hi,
    output logic          rsp_fault,
    output logic [TW-1:0] rsp_tag_amt
);
    logic          accept;
    logic          upper_el;
    logic [TW-1:0] tag_amt;
    logic [1:0]    hits;
    logic          nxt_sel_hi;
    logic          nxt_fault;
    xlt_result_t   res_q;
    logic          unused_ctl_bits;

    assign req_ready       = 1'b1;
    assign accept          = req_valid && req_ready;
    assign upper_el        = is_upper_el(req_aa64, req_el);
    assign unused_ctl_bits = ^req_ctl;

    xlt_tag_pick #(.TW(TW)) u_tag (
        .aa64       (req_aa64),
        .upper_el   (upper_el),
        .va_half    (req_va[VA_HALF_BIT]),
        .tag_upper  (req_ctl[CB_TAG_UPPER]),
        .tag_el1_lo (req_ctl[CB_TAG_EL1_LO]),
        .tag_el1_hi (req_ctl[CB_TAG_EL1_HI]),
        .tag_amt    (tag_amt)
    );

    for (genvar g = 0; g < 2; g++) begin : g_region
        xlt_region_match #(
            .AW(AW), .SW(SW), .TW(TW), .MATCH_ONE(g == 1)
        ) u_match (
            .va      (req_va),
            .aa64    (req_aa64),
            .tsz     (g == 0 ? req_t0sz : req_t1sz),
            .tag_amt (tag_amt),
            .hit     (hits[g])
        );
    end

    xlt_sel_arbiter u_arb (
        .hit_lo      (hits[0]),
        .hit_hi      (hits[1]),
        .t0_zero     (req_t0sz == '0),
        .t1_zero     (req_t1sz == '0),
        .hi_ok       (!upper_el),
        .walk_off_lo (req_ctl[CB_WALK_OFF_LO]),
        .walk_off_hi (req_ctl[CB_WALK_OFF_HI]),
        .sel_hi      (nxt_sel_hi),
        .fault       (nxt_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                res_q.sel_hi  <= nxt_sel_hi;
                res_q.fault   <= nxt_fault;
                res_q.tag_amt <= tag_amt;
            end
        end
    end

    assign rsp_sel_hi  = res_q.sel_hi;
    assign rsp_fault   = res_q.fault;
    assign rsp_tag_amt = res_q.tag_amt;
endmodule

// File: rtl/xlt_base_sel_chk.sv
module xlt_base_sel_chk
    import xlt_sel_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [EL_W-1:0]  req_el,
    input logic             req_aa64,
    input logic [CTL_W-1:0] req_ctl,
    input logic             rsp_valid,
    input logic             rsp_sel_hi,
    input logic             rsp_fault,
    input logic [TAG_W-1:0] rsp_tag_amt
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst) req_ready); // R2
    AST_RSP_AFTER_ACC: assert property (@(posedge clk) disable iff (rst) acc |=> rsp_valid); // R2
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst) !acc |=> !rsp_valid); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !acc |=> ($stable(rsp_sel_hi) && $stable(rsp_fault) && $stable(rsp_tag_amt))); // R3
    AST_NO_HI_UPPER: assert property (@(posedge clk) disable iff (rst)
        (acc && req_aa64 && req_el >= 2'd2) |=> !rsp_sel_hi); // R9
    AST_TAG_32BIT: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_aa64) |=> (rsp_tag_amt == '0)); // R6
    AST_BOTH_WALK_OFF: assert property (@(posedge clk) disable iff (rst)
        (acc && req_ctl[CB_WALK_OFF_LO] && req_ctl[CB_WALK_OFF_HI]) |=> rsp_fault); // R10
endmodule

bind xlt_base_sel xlt_base_sel_chk chk_i (.*);

// File: tb/xlt_base_sel_tb.sv
`timescale 1ns/1ps
module xlt_base_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_va;
    logic [1:0]  req_el;
    logic        req_aa64;
    logic [63:0] req_ctl;
    logic [5:0]  req_t0sz;
    logic [5:0]  req_t1sz;
    logic        rsp_valid;
    logic        rsp_sel_hi;
    logic        rsp_fault;
    logic [3:0]  rsp_tag_amt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    xlt_base_sel dut_i (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic bit field_is(input logic [63:0] va, input int vsz,
                                    input int tsz, input int tg, input bit one);
        for (int i = vsz - tsz; i < vsz - tg; i++)
            if (i >= 0 && va[i] != one) return 1'b0;
        return 1'b1;
    endfunction

    function automatic void model(input logic [63:0] va, input logic [1:0] el,
                                  input bit aa64, input logic [63:0] ctl,
                                  input int t0, input int t1,
                                  output bit sel, output bit flt, output int tg);
        int  vsz = aa64 ? 64 : 32;
        bit  upper = aa64 && (el >= 2);
        bit  en;
        bit  hi_ok = !upper;
        int  pick;  // 0 low, 1 high, 2 none
        en = 1'b0;
        if (aa64) en = upper ? ctl[20] : (va[55] ? ctl[38] : ctl[37]);
        tg = en ? 8 : 0;
        if (t0 != 0 && field_is(va, vsz, t0, tg, 1'b0))               pick = 0;
        else if (hi_ok && t1 != 0 && field_is(va, vsz, t1, tg, 1'b1)) pick = 1;
        else if (t0 == 0)                                             pick = 0;
        else if (t1 == 0 && hi_ok)                                    pick = 1;
        else                                                          pick = 2;
        sel = (pick == 1);
        flt = (pick == 2) || (pick == 0 && ctl[7]) || (pick == 1 && ctl[23]);
    endfunction

    // drive on negedge, check result on the next negedge, then check hold
    task automatic run(input string rq, input logic [63:0] va, input logic [1:0] el,
                       input bit aa64, input logic [63:0] ctl,
                       input logic [5:0] t0, input logic [5:0] t1);
        bit e_sel, e_flt;
        int e_tag;
        model(va, el, aa64, ctl, int'(t0), int'(t1), e_sel, e_flt, e_tag);
        req_valid = 1'b1; req_va = va; req_el = el; req_aa64 = aa64;
        req_ctl = ctl; req_t0sz = t0; req_t1sz = t1;
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R2", "rsp_valid after accept", 64'(rsp_valid), 64'd1);
        chk(rsp_sel_hi == e_sel, rq, "sel_hi", 64'(rsp_sel_hi), 64'(e_sel));
        chk(rsp_fault == e_flt, rq, "fault", 64'(rsp_fault), 64'(e_flt));
        chk(int'(rsp_tag_amt) == e_tag, rq, "tag_amt", 64'(rsp_tag_amt), 64'(e_tag));
        req_valid = 1'b0;
        req_va = ~va; req_ctl = ~ctl; req_el = ~el; req_aa64 = ~aa64;
        req_t0sz = ~t0; req_t1sz = ~t1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
        chk(rsp_sel_hi == e_sel && rsp_fault == e_flt && int'(rsp_tag_amt) == e_tag,
            "R3", "held result", {rsp_sel_hi, rsp_fault, rsp_tag_amt},
            {e_sel, e_flt, 4'(e_tag)});
    endtask

    function automatic logic [63:0] pick_va(input int kind);
        logic [63:0] v = {$urandom, $urandom};
        case (kind)
            0: v = v >> ($urandom_range(8, 40));
            1: v = ~(v >> ($urandom_range(8, 40)));
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; req_valid = 1'b1; req_va = '0; req_el = 2'd1; req_aa64 = 1'b1;
        req_ctl = '1; req_t0sz = '0; req_t1sz = '0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_fault == 1'b0, "R1", "in reset",
            {rsp_valid, rsp_fault}, 64'd0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_fault == 1'b0, "R1", "after reset",
            {rsp_valid, rsp_fault}, 64'd0);
        chk(req_ready == 1'b1, "R2", "ready", 64'(req_ready), 64'd1);

        // R8 low region hit, high region hit, neither
        run("R8", 64'h0000_1234_5678_9abc, 2'd1, 1'b1, 64'd0, 6'd16, 6'd16);
        run("R8", 64'hffff_8000_0000_0000, 2'd1, 1'b1, 64'd0, 6'd16, 6'd16);
        run("R8", 64'h00ff_0000_0000_0000, 2'd1, 1'b1, 64'd0, 6'd16, 6'd16);
        run("R8", 64'h00ff_0000_0000_0000, 2'd1, 1'b1, 64'd0, 6'd0,  6'd16);
        run("R8", 64'h00ff_0000_0000_0000, 2'd1, 1'b1, 64'd0, 6'd16, 6'd0);
        // R7 field edge: bit (64-T0SZ) set leaves the low region
        run("R7", 64'h0001_0000_0000_0000, 2'd1, 1'b1, 64'd0, 6'd16, 6'd16);
        run("R7", 64'h0000_8000_0000_0000, 2'd1, 1'b1, 64'd0, 6'd16, 6'd16);
        // R9 upper EL never picks register 1
        run("R9", 64'hffff_8000_0000_0000, 2'd2, 1'b1, 64'd0, 6'd16, 6'd16);
        run("R9", 64'hffff_8000_0000_0000, 2'd3, 1'b1, 64'd0, 6'd16, 6'd0);
        // R10 / R11 walk disable
        run("R10", 64'hffff_8000_0000_0000, 2'd1, 1'b1, 64'h80_0000, 6'd16, 6'd16);
        run("R11", 64'h0000_0000_0000_1000, 2'd1, 1'b1, 64'h80, 6'd16, 6'd16);
        // R4 tag ignore at EL1: top byte garbage, bit 55 picks control bit
        run("R4", 64'h5aff_8000_0000_0000, 2'd1, 1'b1, 64'h40_0000_0000, 6'd16, 6'd16);
        run("R4", 64'h5a00_0000_0000_0000, 2'd1, 1'b1, 64'h20_0000_0000, 6'd16, 6'd16);
        run("R4", 64'h5a00_0000_0000_0000, 2'd1, 1'b1, 64'h40_0000_0000, 6'd16, 6'd16);
        // R5 upper EL uses bit 20 only
        run("R5", 64'h5a00_0000_0000_0000, 2'd2, 1'b1, 64'h10_0000, 6'd16, 6'd16);
        run("R5", 64'h5a80_0000_0000_0000, 2'd3, 1'b1, 64'h60_0000_0000, 6'd16, 6'd16);
        // R6 32-bit regime
        run("R6", 64'h0000_0000_00ff_1234, 2'd1, 1'b0, 64'h60_0010_0000, 6'd8, 6'd8);
        run("R6", 64'h0000_0000_ff00_1234, 2'd1, 1'b0, 64'h60_0010_0000, 6'd8, 6'd8);

        for (int n = 0; n < 400; n++) begin
            logic [63:0] c = {$urandom, $urandom};
            c = c & ({$urandom, $urandom} | ~64'h0000_0060_0090_0080);
            run("R8", pick_va($urandom_range(0, 2)), 2'($urandom_range(0, 3)),
                1'($urandom_range(0, 3) != 0), c,
                ($urandom_range(0, 4) == 0) ? 6'd0 : 6'($urandom_range(1, 40)),
                ($urandom_range(0, 4) == 0) ? 6'd0 : 6'($urandom_range(1, 40)));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule